// File: doc/BRIEF.md
# Error Severity Signaling Controller

This block takes one detected error event per cycle and settles everything that follows from it. It checks the error code against the set of codes its class supports. It decides whether the event travels as a correctable or an uncorrectable error and, for uncorrectable ones, whether it is fatal. A non-fatal error that may be advisory can be turned into a correctable advisory error. The block sets the matching device-status and per-class status bits and honours the mask registers. When an uncorrectable error has to be recorded, it raises a request toward an external header-logging block. Finally it decides whether an error message goes upstream, and with which severity and requester ID.

The surrounding function supplies the reporting enables, the system-error enable, the severity register and both mask registers as plain inputs. The logging block answers a log request in the same cycle with an overflow flag. When that flag is raised, the controller spends the next cycle on a header-log-overflow correctable error through the same decision path. During that cycle it drops its ready output. Log storage and upstream routing sit outside this block.

Top module: `err_sev_ctrl`

## Requirements
- R1: The event code is ANDed with the supported set of its class: correctable bits 0, 6, 7, 8, 12, 13, 14, 15 and uncorrectable bits 4, 5 and 12 to 25. If the result is zero or has more than one bit set, the event is dropped: no status bit changes, no log request and no message.
- R2: With the capability present, an uncorrectable error is fatal when its bit in the severity input is set. Without the capability, bits 4, 5, 13, 17, 18 and 22 are fatal and all other supported bits are non-fatal.
- R3: A correctable error sets device-status bit 0. It also sets bit 3 when the error is an unsupported request (uncorrectable bit 20). With the capability present, it sets its bit in the correctable status. When its correctable mask bit is set, no message is sent.
- R4: A non-fatal error with the possibly-advisory flag becomes correctable bit 13. If correctable mask bit 13 is set, only that correctable status bit changes. Otherwise the original bit is set in the uncorrectable status, and a log request is raised only when that bit's uncorrectable mask is clear.
- R5: An uncorrectable error on the non-advisory path sets device-status bit 2 if it is fatal and bit 1 if it is non-fatal. With the capability present, its uncorrectable status bit is always set. When its uncorrectable mask bit is set, there is no log request and no message; otherwise a log request is raised.
- R6: The log request is combinational in the event cycle. It carries the single uncorrectable bit and the event's requester ID.
- R7: A correctable message needs the correctable reporting enable. A non-fatal message needs the system-error enable or the non-fatal enable. A fatal message needs the system-error enable or the fatal enable. Severity codes are 0 for correctable, 1 for non-fatal and 2 for fatal.
- R8: An unsupported-request error with its reporting enable off sends no correctable message. On the uncorrectable path, it sends no message when the system-error enable is also off.
- R9: The message strobe, severity and requester ID appear on the clock edge that ends the event cycle.
- R10: A log request answered with overflow makes the next cycle process correctable bit 15 with the same requester ID. During that cycle ready is low and any input event is ignored.
- R11: Without the capability, neither status register changes and no log request is raised.
- R12: Status bits stay set until reset, and reset clears every status bit and the message strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | Error event strobe |
| evt_ready | output | 1 | Low during the overflow follow-up cycle |
| evt_code | input | UNC_W | Error code, one bit expected |
| evt_is_cor | input | 1 | Event belongs to the correctable class |
| evt_maybe_adv | input | 1 | Non-fatal event may be treated as advisory |
| evt_rid | input | RID_W | Requester ID of the event |
| cap_on | input | 1 | Extended error capability present |
| sev_reg | input | UNC_W | Uncorrectable severity register (1 = fatal) |
| unc_mask | input | UNC_W | Uncorrectable mask register |
| cor_mask | input | COR_W | Correctable mask register |
| en_cor | input | 1 | Correctable reporting enable |
| en_nonfatal | input | 1 | Non-fatal reporting enable |
| en_fatal | input | 1 | Fatal reporting enable |
| en_ur | input | 1 | Unsupported-request reporting enable |
| serr_en | input | 1 | System-error enable from the command register |
| log_req | output | 1 | Request to record the error header |
| log_code | output | UNC_W | Uncorrectable bit to record |
| log_rid | output | RID_W | Requester ID to record |
| log_overflow | input | 1 | Same-cycle answer: the log is full |
| msg_valid | output | 1 | Error message strobe |
| msg_sev | output | 2 | Message severity code |
| msg_rid | output | RID_W | Message requester ID |
| dev_sta | output | 4 | Device status: 0 cor, 1 non-fatal, 2 fatal, 3 UR |
| cor_sta | output | COR_W | Correctable status register |
| unc_sta | output | UNC_W | Uncorrectable status register |

## Verification
The log request and its code and ID are combinational, so the bench reads them one nanosecond after it drives the event at a falling edge. The message and all three status registers are due at the next rising edge, and the bench reads them at the falling edge that follows. When overflow is expected, the bench first reads ready low at that same falling edge. It then reads the follow-up message and status one further falling edge later. A distracting event is held on the inputs during that cycle, and its effect must not appear.

// File: rtl/err_sev_pkg.sv
package err_sev_pkg;

  localparam int DS_W     = 4;
  localparam int DS_COR   = 0;
  localparam int DS_NF    = 1;
  localparam int DS_FATAL = 2;
  localparam int DS_UR    = 3;

  typedef enum logic [1:0] {
    SEV_COR      = 2'd0,
    SEV_NONFATAL = 2'd1,
    SEV_FATAL    = 2'd2
  } sev_e;

  // exactly one bit set
  function automatic logic one_bit(input logic [31:0] v);
    return (v != 32'd0) && ((v & (v - 32'd1)) == 32'd0);
  endfunction

  // fatality from the severity register or the fixed default set
  function automatic logic pick_fatal(input logic [31:0] v, input logic [31:0] sev,
                                      input logic [31:0] dflt, input logic cap);
    return cap ? ((v & sev) != 32'd0) : ((v & dflt) != 32'd0);
  endfunction

  // uncorrectable message enable: system error or class-specific enable
  function automatic logic unc_allowed(input logic fatal, input logic serr,
                                       input logic en_nf, input logic en_f);
    return serr || (fatal ? en_f : en_nf);
  endfunction

  // unsupported-request veto
  function automatic logic ur_veto(input logic is_ur, input logic en_ur,
                                   input logic serr_ok);
    return is_ur && !en_ur && !serr_ok;
  endfunction

endpackage

// File: rtl/err_sev_classify.sv
module err_sev_classify #(
  parameter int                 COR_W     = 16,
  parameter int                 UNC_W     = 32,
  parameter logic [COR_W-1:0]   COR_SUPP  = 16'hF1C1,
  parameter logic [UNC_W-1:0]   UNC_SUPP  = 32'h03FF_F030,
  parameter logic [UNC_W-1:0]   DEF_FATAL = 32'h0046_2030,
  parameter int                 UR_BIT    = 20
) (
  input  logic [UNC_W-1:0] raw_code,
  input  logic             is_cor,
  input  logic             cap_on,
  input  logic [UNC_W-1:0] sev_reg,
  output logic             accept,
  output logic [UNC_W-1:0] err_vec,
  output logic             is_ur,
  output logic             fatal
);
  import err_sev_pkg::*;

  localparam logic [UNC_W-1:0] COR_SUPP_X = UNC_W'(COR_SUPP);
  localparam logic [UNC_W-1:0] UR_VEC     = UNC_W'(1) << UR_BIT;

  always_comb begin
    err_vec = raw_code & (is_cor ? COR_SUPP_X : UNC_SUPP);
    accept  = one_bit(32'(err_vec));
    is_ur   = !is_cor && (err_vec == UR_VEC);
    fatal   = !is_cor && pick_fatal(32'(err_vec), 32'(sev_reg), 32'(DEF_FATAL), cap_on);
  end

endmodule

// File: rtl/err_sev_decide.sv
module err_sev_decide #(
  parameter int COR_W   = 16,
  parameter int UNC_W   = 32,
  parameter int ADV_BIT = 13
) (
  input  logic             accept,
  input  logic [UNC_W-1:0] err_vec,
  input  logic             is_cor,
  input  logic             is_ur,
  input  logic             fatal,
  input  logic             maybe_adv,
  input  logic             cap_on,
  input  logic [COR_W-1:0] cor_mask,
  input  logic [UNC_W-1:0] unc_mask,
  input  logic             en_cor,
  input  logic             en_nonfatal,
  input  logic             en_fatal,
  input  logic             en_ur,
  input  logic             serr_en,
  output logic             send,
  output logic [1:0]       sev,
  output logic             log_hit,
  output logic             adv_path,
  output logic [err_sev_pkg::DS_W-1:0] dsta_set,
  output logic [COR_W-1:0] cor_set,
  output logic [UNC_W-1:0] unc_set
);
  import err_sev_pkg::*;

  localparam logic [COR_W-1:0] ADV_VEC = COR_W'(1) << ADV_BIT;

  logic             cor_path;
  logic [COR_W-1:0] cor_bit;
  logic             gate;

  always_comb begin
    send     = 1'b0;
    sev      = SEV_COR;
    log_hit  = 1'b0;
    adv_path = 1'b0;
    dsta_set = '0;
    cor_set  = '0;
    unc_set  = '0;
    cor_path = 1'b0;
    cor_bit  = '0;
    gate     = 1'b0;
    if (accept) begin
      if (is_cor) begin
        cor_path = 1'b1;
        cor_bit  = err_vec[COR_W-1:0];
      end else if (!fatal && maybe_adv) begin
        cor_path = 1'b1;
        adv_path = 1'b1;
        cor_bit  = ADV_VEC;
      end
      if (cor_path) begin
        dsta_set[DS_COR] = 1'b1;
        dsta_set[DS_UR]  = is_ur;
        gate = 1'b1;
        if (cap_on) begin
          cor_set = cor_bit;
          if ((cor_mask & cor_bit) != '0) begin
            gate = 1'b0;
          end else if (adv_path) begin
            log_hit = ((unc_mask & err_vec) == '0);
            unc_set = err_vec;
          end
        end
        if (ur_veto(is_ur, en_ur, 1'b0)) gate = 1'b0;
        if (!en_cor)                     gate = 1'b0;
        send = gate;
        sev  = SEV_COR;
      end else begin
        dsta_set[DS_FATAL] = fatal;
        dsta_set[DS_NF]    = !fatal;
        dsta_set[DS_UR]    = is_ur;
        gate = 1'b1;
        if (cap_on) begin
          unc_set = err_vec;
          if ((unc_mask & err_vec) != '0) gate = 1'b0;
          else                            log_hit = 1'b1;
        end
        if (ur_veto(is_ur, en_ur, serr_en))                         gate = 1'b0;
        if (!unc_allowed(fatal, serr_en, en_nonfatal, en_fatal))    gate = 1'b0;
        send = gate;
        sev  = fatal ? SEV_FATAL : SEV_NONFATAL;
      end
    end
  end

endmodule

// File: rtl/err_sev_regs.sv
module err_sev_regs #(
  parameter int COR_W = 16,
  parameter int UNC_W = 32,
  parameter int RID_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             send,
  input  logic [1:0]       sev,
  input  logic [RID_W-1:0] rid,
  input  logic [err_sev_pkg::DS_W-1:0] dsta_set,
  input  logic [COR_W-1:0] cor_set,
  input  logic [UNC_W-1:0] unc_set,
  input  logic             ovf_hit,
  output logic             msg_valid,
  output logic [1:0]       msg_sev,
  output logic [RID_W-1:0] msg_rid,
  output logic [err_sev_pkg::DS_W-1:0] dev_sta,
  output logic [COR_W-1:0] cor_sta,
  output logic [UNC_W-1:0] unc_sta,
  output logic             ovf_pend,
  output logic [RID_W-1:0] pend_rid
);
  import err_sev_pkg::*;

  for (genvar i = 0; i < DS_W; i++) begin : g_ds
    logic cell_q;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                     cell_q <= 1'b0;
      else if (take && dsta_set[i])   cell_q <= 1'b1;
    assign dev_sta[i] = cell_q;
  end

  for (genvar i = 0; i < COR_W; i++) begin : g_cor
    logic cell_q;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                     cell_q <= 1'b0;
      else if (take && cor_set[i])    cell_q <= 1'b1;
    assign cor_sta[i] = cell_q;
  end

  for (genvar i = 0; i < UNC_W; i++) begin : g_unc
    logic cell_q;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                     cell_q <= 1'b0;
      else if (take && unc_set[i])    cell_q <= 1'b1;
    assign unc_sta[i] = cell_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_sev   <= SEV_COR;
      msg_rid   <= '0;
      ovf_pend  <= 1'b0;
      pend_rid  <= '0;
    end else begin
      msg_valid <= take && send;
      if (take && send) begin
        msg_sev <= sev;
        msg_rid <= rid;
      end
      ovf_pend <= take && ovf_hit;
      if (take && ovf_hit) pend_rid <= rid;
    end
  end

endmodule

// File: rtl/err_sev_ctrl.sv
module err_sev_ctrl #(
  parameter int               COR_W     = 16,
  parameter int               UNC_W     = 32,
  parameter int               RID_W     = 16,
  parameter logic [COR_W-1:0] COR_SUPP  = 16'hF1C1,
  parameter logic [UNC_W-1:0] UNC_SUPP  = 32'h03FF_F030,
  parameter logic [UNC_W-1:0] DEF_FATAL = 32'h0046_2030,
  parameter int               UR_BIT    = 20,
  parameter int               ADV_BIT   = 13,
  parameter int               HLO_BIT   = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_valid,
  output logic             evt_ready,
  input  logic [UNC_W-1:0] evt_code,
  input  logic             evt_is_cor,
  input  logic             evt_maybe_adv,
  input  logic [RID_W-1:0] evt_rid,
  input  logic             cap_on,
  input  logic [UNC_W-1:0] sev_reg,
  input  logic [UNC_W-1:0] unc_mask,
  input  logic [COR_W-1:0] cor_mask,
  input  logic             en_cor,
  input  logic             en_nonfatal,
  input  logic             en_fatal,
  input  logic             en_ur,
  input  logic             serr_en,
  output logic             log_req,
  output logic [UNC_W-1:0] log_code,
  output logic [RID_W-1:0] log_rid,
  input  logic             log_overflow,
  output logic             msg_valid,
  output logic [1:0]       msg_sev,
  output logic [RID_W-1:0] msg_rid,
  output logic [3:0]       dev_sta,
  output logic [COR_W-1:0] cor_sta,
  output logic [UNC_W-1:0] unc_sta
);
  import err_sev_pkg::*;

  localparam logic [UNC_W-1:0] HLO_VEC = UNC_W'(1) << HLO_BIT;

  // named internal events
  logic             ovf_pend;
  logic [RID_W-1:0] pend_rid;
  logic             evt_take;
  logic [UNC_W-1:0] cur_code;
  logic             cur_is_cor;
  logic             cur_adv;
  logic [RID_W-1:0] cur_rid;
  logic             accept_w;
  logic [UNC_W-1:0] err_vec;
  logic             is_ur;
  logic             fatal;
  logic             send_w;
  logic [1:0]       sev_w;
  logic             log_hit;
  logic             adv_path;
  logic [DS_W-1:0]  dsta_set;
  logic [COR_W-1:0] cor_set;
  logic [UNC_W-1:0] unc_set;
  logic             ovf_hit;

  // the overflow follow-up takes precedence over a new event
  assign evt_ready  = !ovf_pend;
  assign evt_take   = ovf_pend || evt_valid;
  assign cur_code   = ovf_pend ? HLO_VEC  : evt_code;
  assign cur_is_cor = ovf_pend ? 1'b1     : evt_is_cor;
  assign cur_adv    = ovf_pend ? 1'b0     : evt_maybe_adv;
  assign cur_rid    = ovf_pend ? pend_rid : evt_rid;

  err_sev_classify #(
    .COR_W(COR_W), .UNC_W(UNC_W), .COR_SUPP(COR_SUPP),
    .UNC_SUPP(UNC_SUPP), .DEF_FATAL(DEF_FATAL), .UR_BIT(UR_BIT)
  ) u_classify (
    .raw_code (cur_code),
    .is_cor   (cur_is_cor),
    .cap_on   (cap_on),
    .sev_reg  (sev_reg),
    .accept   (accept_w),
    .err_vec  (err_vec),
    .is_ur    (is_ur),
    .fatal    (fatal)
  );

  err_sev_decide #(
    .COR_W(COR_W), .UNC_W(UNC_W), .ADV_BIT(ADV_BIT)
  ) u_decide (
    .accept      (accept_w),
    .err_vec     (err_vec),
    .is_cor      (cur_is_cor),
    .is_ur       (is_ur),
    .fatal       (fatal),
    .maybe_adv   (cur_adv),
    .cap_on      (cap_on),
    .cor_mask    (cor_mask),
    .unc_mask    (unc_mask),
    .en_cor      (en_cor),
    .en_nonfatal (en_nonfatal),
    .en_fatal    (en_fatal),
    .en_ur       (en_ur),
    .serr_en     (serr_en),
    .send        (send_w),
    .sev         (sev_w),
    .log_hit     (log_hit),
    .adv_path    (adv_path),
    .dsta_set    (dsta_set),
    .cor_set     (cor_set),
    .unc_set     (unc_set)
  );

  assign log_req  = evt_take && log_hit;
  assign log_code = err_vec;
  assign log_rid  = cur_rid;
  assign ovf_hit  = log_req && log_overflow;

  err_sev_regs #(
    .COR_W(COR_W), .UNC_W(UNC_W), .RID_W(RID_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (evt_take),
    .send      (send_w),
    .sev       (sev_w),
    .rid       (cur_rid),
    .dsta_set  (dsta_set),
    .cor_set   (cor_set),
    .unc_set   (unc_set),
    .ovf_hit   (ovf_hit),
    .msg_valid (msg_valid),
    .msg_sev   (msg_sev),
    .msg_rid   (msg_rid),
    .dev_sta   (dev_sta),
    .cor_sta   (cor_sta),
    .unc_sta   (unc_sta),
    .ovf_pend  (ovf_pend),
    .pend_rid  (pend_rid)
  );

endmodule

// File: rtl/err_sev_ctrl_chk.sv
module err_sev_ctrl_chk #(
  parameter int COR_W   = 16,
  parameter int UNC_W   = 32,
  parameter int ADV_BIT = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             evt_take,
  input logic             accept_w,
  input logic             adv_path,
  input logic             cap_on,
  input logic             ovf_pend,
  input logic             log_req,
  input logic             log_overflow,
  input logic [UNC_W-1:0] log_code,
  input logic             msg_valid,
  input logic [1:0]       msg_sev,
  input logic [3:0]       dev_sta,
  input logic [COR_W-1:0] cor_sta,
  input logic [UNC_W-1:0] unc_sta
);

  // R1
  reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_take && !accept_w) |=> ($stable(cor_sta) && $stable(unc_sta) && $stable(dev_sta) && !msg_valid));

  // R4
  adv_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_take && adv_path && cap_on) |=> cor_sta[ADV_BIT]);

  // R6
  log_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    log_req |-> $onehot(log_code));

  // R7
  sev_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_sev != 2'b11));

  // R9
  msg_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> $past(evt_take));

  // R10
  ovf_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_pend) |-> $past(log_req && log_overflow));

  // R12
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(dev_sta) & ~dev_sta) == 4'd0) && (($past(cor_sta) & ~cor_sta) == '0)
     && (($past(unc_sta) & ~unc_sta) == '0)));

endmodule

bind err_sev_ctrl err_sev_ctrl_chk #(
  .COR_W(COR_W), .UNC_W(UNC_W), .ADV_BIT(ADV_BIT)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .evt_take     (evt_take),
  .accept_w     (accept_w),
  .adv_path     (adv_path),
  .cap_on       (cap_on),
  .ovf_pend     (ovf_pend),
  .log_req      (log_req),
  .log_overflow (log_overflow),
  .log_code     (log_code),
  .msg_valid    (msg_valid),
  .msg_sev      (msg_sev),
  .dev_sta      (dev_sta),
  .cor_sta      (cor_sta),
  .unc_sta      (unc_sta)
);

// File: tb/err_sev_ctrl_test.sv
`timescale 1ns/1ps
module err_sev_ctrl_test;

  localparam logic [15:0] COR_OK = 16'hF1C1;
  localparam logic [31:0] UNC_OK = 32'h03FF_F030;
  localparam logic [31:0] DEF_F  = 32'h0046_2030;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_valid = 1'b0;
  logic        evt_ready;
  logic [31:0] evt_code = '0;
  logic        evt_is_cor = 1'b0;
  logic        evt_maybe_adv = 1'b0;
  logic [15:0] evt_rid = '0;
  logic        cap_on = 1'b1;
  logic [31:0] sev_reg = '0;
  logic [31:0] unc_mask = '0;
  logic [15:0] cor_mask = '0;
  logic        en_cor = 1'b0, en_nonfatal = 1'b0, en_fatal = 1'b0, en_ur = 1'b0, serr_en = 1'b0;
  logic        log_req;
  logic [31:0] log_code;
  logic [15:0] log_rid;
  logic        log_overflow = 1'b0;
  logic        msg_valid;
  logic [1:0]  msg_sev;
  logic [15:0] msg_rid;
  logic [3:0]  dev_sta;
  logic [15:0] cor_sta;
  logic [31:0] unc_sta;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;
  logic [3:0]  exp_dev;
  logic [15:0] exp_cor;
  logic [31:0] exp_unc;

  always #4 clk = ~clk;

  err_sev_ctrl uut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_code(evt_code), .evt_is_cor(evt_is_cor), .evt_maybe_adv(evt_maybe_adv),
    .evt_rid(evt_rid), .cap_on(cap_on), .sev_reg(sev_reg), .unc_mask(unc_mask),
    .cor_mask(cor_mask), .en_cor(en_cor), .en_nonfatal(en_nonfatal),
    .en_fatal(en_fatal), .en_ur(en_ur), .serr_en(serr_en), .log_req(log_req),
    .log_code(log_code), .log_rid(log_rid), .log_overflow(log_overflow),
    .msg_valid(msg_valid), .msg_sev(msg_sev), .msg_rid(msg_rid),
    .dev_sta(dev_sta), .cor_sta(cor_sta), .unc_sta(unc_sta)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // independent reference of the decision, written as a flat table walk
  function automatic void model(input logic [31:0] b, input bit c, input bit a,
      output bit acc, output bit snd, output logic [1:0] sv, output bit lg,
      output logic [3:0] ds, output logic [15:0] cs, output logic [31:0] us,
      output string tag);
    logic [31:0] v;
    bit ur, fat, advp, blocked;
    logic [15:0] cb;
    acc = 0; snd = 0; sv = 2'd0; lg = 0; ds = '0; cs = '0; us = '0; tag = "R1";
    v = b & (c ? {16'h0, COR_OK} : UNC_OK);
    if ($countones(v) != 1) return;
    acc  = 1;
    ur   = !c && (v == 32'h0010_0000);
    fat  = 0;
    if (!c) fat = cap_on ? ((v & sev_reg) != 0) : ((v & DEF_F) != 0);
    advp = !c && !fat && a;
    blocked = 0;
    if (c || advp) begin
      cb  = c ? v[15:0] : 16'h2000;
      tag = advp ? "R4" : "R3";
      ds  = {ur, 2'b00, 1'b1};
      if (cap_on) begin
        cs = cb;
        if ((cor_mask & cb) != 0) blocked = 1;
        else if (advp) begin
          us = v;
          lg = ((unc_mask & v) == 0);
        end
      end
      if (ur && !en_ur) blocked = 1;
      if (!en_cor) blocked = 1;
      sv = 2'd0;
    end else begin
      tag = "R5";
      ds  = {ur, fat, !fat, 1'b0};
      if (cap_on) begin
        us = v;
        if ((unc_mask & v) != 0) blocked = 1; else lg = 1;
      end
      if (ur && !en_ur && !serr_en) blocked = 1;
      if (fat && !(serr_en || en_fatal)) blocked = 1;
      if (!fat && !(serr_en || en_nonfatal)) blocked = 1;
      sv = fat ? 2'd2 : 2'd1;
    end
    snd = !blocked;
    if (ur) tag = "R8";
    if (!cap_on) tag = "R11";
  endfunction

  task automatic check_state(input string tag);
    chk(dev_sta == exp_dev, tag, "dev_sta", 32'(dev_sta), 32'(exp_dev));
    chk(cor_sta == exp_cor, tag, "cor_sta", 32'(cor_sta), 32'(exp_cor));
    chk(unc_sta == exp_unc, tag, "unc_sta", unc_sta, exp_unc);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; evt_valid = 1'b0; log_overflow = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    exp_dev = '0; exp_cor = '0; exp_unc = '0;
    @(negedge clk);
    chk(msg_valid == 1'b0, "R12", "msg_valid after reset", 32'(msg_valid), 0);
    check_state("R12");
  endtask

  task automatic run_evt(input logic [31:0] b, input bit c, input bit a,
                         input logic [15:0] id, input bit ovf, input string tag_in);
    bit acc, snd, lg, snd2, acc2, lg2;
    logic [1:0] sv, sv2;
    logic [3:0] ds, ds2;
    logic [15:0] cs, cs2;
    logic [31:0] us, us2;
    string tag, tag2;
    model(b, c, a, acc, snd, sv, lg, ds, cs, us, tag);
    if (tag_in != "") tag = tag_in;
    evt_code = b; evt_is_cor = c; evt_maybe_adv = a; evt_rid = id;
    log_overflow = ovf; evt_valid = 1'b1;
    #1;
    chk(evt_ready == 1'b1, "R10", "ready before event", 32'(evt_ready), 1);
    chk(log_req == lg, (lg && tag == "R3") ? "R6" : tag, "log_req", 32'(log_req), 32'(lg));
    if (lg) begin
      chk(log_code == (b & UNC_OK), "R6", "log_code", log_code, b & UNC_OK);
      chk(log_rid == id, "R6", "log_rid", 32'(log_rid), 32'(id));
    end
    @(negedge clk);
    evt_valid = 1'b0; log_overflow = 1'b0;
    if (acc) begin exp_dev |= ds; exp_cor |= cs; exp_unc |= us; end
    chk(msg_valid == snd, tag, "msg_valid", 32'(msg_valid), 32'(snd));
    if (snd) begin
      chk(msg_sev == sv, (tag_in == "R2") ? "R2" : "R7", "msg_sev", 32'(msg_sev), 32'(sv));
      chk(msg_rid == id, "R9", "msg_rid", 32'(msg_rid), 32'(id));
    end
    check_state(tag);
    if (lg && ovf) begin
      chk(evt_ready == 1'b0, "R10", "ready in follow-up", 32'(evt_ready), 0);
      // distracting event that must be ignored
      evt_code = 32'h0000_1000; evt_is_cor = 1'b0; evt_maybe_adv = 1'b0;
      evt_rid = ~id; evt_valid = 1'b1;
      model(32'h0000_8000, 1'b1, 1'b0, acc2, snd2, sv2, lg2, ds2, cs2, us2, tag2);
      #1;
      chk(log_req == 1'b0, "R10", "no log in follow-up", 32'(log_req), 0);
      @(negedge clk);
      evt_valid = 1'b0;
      exp_dev |= ds2; exp_cor |= cs2; exp_unc |= us2;
      chk(msg_valid == snd2, "R10", "overflow msg_valid", 32'(msg_valid), 32'(snd2));
      if (snd2) begin
        chk(msg_sev == 2'd0, "R10", "overflow sev", 32'(msg_sev), 0);
        chk(msg_rid == id, "R10", "overflow rid", 32'(msg_rid), 32'(id));
      end
      check_state("R10");
    end
  endtask

  task automatic set_cfg(input bit cap, input logic [31:0] sv, input logic [31:0] um,
                         input logic [15:0] cm, input logic [4:0] en);
    cap_on = cap; sev_reg = sv; unc_mask = um; cor_mask = cm;
    {en_cor, en_nonfatal, en_fatal, en_ur, serr_en} = en;
  endtask

  initial begin
    do_reset();
    // R1: empty and double codes
    set_cfg(1, 32'h0, 32'h0, 16'h0, 5'b11111);
    @(negedge clk);
    run_evt(32'h0, 0, 0, 16'h0101, 0, "R1");
    run_evt(32'h0000_3000, 0, 0, 16'h0102, 0, "R1");
    run_evt(32'h0000_0041, 1, 0, 16'h0103, 0, "R1");
    run_evt(32'h0000_0002, 1, 0, 16'h0104, 0, "R1");
    // R2: default fatality without capability, then severity register
    set_cfg(0, 32'h0, 32'h0, 16'h0, 5'b11100);
    run_evt(32'h0004_0000, 0, 0, 16'h0201, 0, "R2");
    run_evt(32'h0000_1000, 0, 0, 16'h0202, 0, "R2");
    set_cfg(1, 32'h0000_1000, 32'h0, 16'h0, 5'b11100);
    run_evt(32'h0000_1000, 0, 0, 16'h0203, 0, "R2");
    do_reset();
    // R3: masked correctable
    set_cfg(1, 32'h0, 32'h0, 16'h0040, 5'b11111);
    run_evt(32'h0000_0040, 1, 0, 16'h0301, 0, "R3");
    run_evt(32'h0000_0080, 1, 0, 16'h0302, 0, "R3");
    // R4: advisory variants
    do_reset();
    set_cfg(1, 32'h0, 32'h0, 16'h0, 5'b10000);
    run_evt(32'h0000_4000, 0, 1, 16'h0401, 0, "R4");
    set_cfg(1, 32'h0, 32'h0000_8000, 16'h0, 5'b10000);
    run_evt(32'h0000_8000, 0, 1, 16'h0402, 0, "R4");
    do_reset();
    set_cfg(1, 32'h0, 32'h0, 16'h2000, 5'b10000);
    run_evt(32'h0001_0000, 0, 1, 16'h0403, 0, "R4");
    // R5: masked uncorrectable
    set_cfg(1, 32'h0, 32'h0080_0000, 16'h0, 5'b11111);
    run_evt(32'h0080_0000, 0, 0, 16'h0501, 0, "R5");
    // R8: unsupported request gating
    set_cfg(1, 32'h0, 32'h0, 16'h0, 5'b11000);
    run_evt(32'h0010_0000, 0, 0, 16'h0801, 0, "R8");
    set_cfg(1, 32'h0, 32'h0, 16'h0, 5'b11001);
    run_evt(32'h0010_0000, 0, 0, 16'h0802, 0, "R8");
    set_cfg(1, 32'h0, 32'h0, 16'h0, 5'b10001);
    run_evt(32'h0010_0000, 0, 1, 16'h0803, 0, "R8");
    // R10: overflow follow-up
    do_reset();
    set_cfg(1, 32'h0, 32'h0, 16'h0, 5'b11111);
    run_evt(32'h0000_0020, 0, 0, 16'h0A01, 1, "R10");
    // R11: no capability
    set_cfg(0, 32'h0, 32'h0, 16'h0, 5'b11111);
    run_evt(32'h0002_0000, 0, 0, 16'h0B01, 1, "R11");
    run_evt(32'h0000_0001, 1, 0, 16'h0B02, 0, "R11");
    // random phase
    void'($urandom(32'd1234));
    for (int n = 0; n < 400; n++) begin
      logic [31:0] b;
      int k;
      if (n % 25 == 0) do_reset();
      set_cfg(($urandom % 6) != 0, $urandom, $urandom & $urandom, 16'($urandom & $urandom),
              5'($urandom));
      k = $urandom % 8;
      if (k == 0)      b = $urandom;
      else if (k == 1) b = 32'h0;
      else             b = 32'h1 << ($urandom % 32);
      run_evt(b, ($urandom % 2) == 1, ($urandom % 2) == 1, 16'($urandom),
              ($urandom % 3) == 0, "");
    end
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL R9 watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule